// File: doc/BRIEF.md
# Embedded-Clock Word Serializer with Sync Generator

This block turns 10-bit parallel words into a serial bitstream. It sends twelve bits per word period. Every data word is wrapped between a fixed high start bit and a fixed low stop bit. These two bits give the receiver a clock edge to recover in every frame. The block runs on a single bit clock and produces its own word boundary every twelfth bit. A `frame_start` flag marks the start-bit cycle.

Either of two sync request inputs makes the block send a training pattern in place of data. The pattern is six ones followed by six zeros, once per word period. A burst of this pattern lasts at least a parameterised number of word periods, 1024 by default. It continues for as long as either request stays high. Parallel words offered during a request are not taken.

An enable input and a power-down input decide whether the serial output is driven. A tri-state pad is modelled here as a valid flag, and the data line is held low while that flag is low. A select input chooses the point in the word period at which the parallel word is captured: early or mid-period.

Top module: `ecw_serializer`

## Requirements
- R1: A frame is 12 bit clocks long and `frame_start` is high during its first bit. In a data frame, bit 0 is the start bit, bits 1 to 10 carry the word least significant bit first (`din[0]` in bit 1), and bit 11 is the stop bit.
- R2: In every driven data frame, the start bit is 1 and the stop bit is 0.
- R3: With `cap_early`=1 the word is captured at the clock edge that ends bit 0 of a frame. With `cap_early`=0 it is captured at the edge that ends bit 6. The captured word is sent in the following frame.
- R4: If `sync_a` or `sync_b` is high at the frame-load edge (the edge ending bit 11), the next frame is a sync frame. In a sync frame, bits 0 to 5 are 1 and bits 6 to 11 are 0.
- R5: A sync burst lasts at least MIN_SYNC (1024) frames, counting from its first sync frame, even if the request drops after one frame.
- R6: Once MIN_SYNC frames have been sent, the burst continues while either request is high at the load edge. The first frame whose load edge sees both requests low (with the minimum met) is a data frame.
- R7: A word is not captured while either sync input is high at its capture edge. The previously captured word is kept and sent in the next data frame.
- R8: `ser_valid` for a frame equals `en & ~pwr_down` sampled at that frame's load edge. While `ser_valid` is 0, `ser_out` is 0.
- R9: After reset, `ser_valid` and `ser_out` stay 0 until the first word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Parallel data word |
| cap_early | input | 1 | Capture phase select: 1 early, 0 mid-period |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| en | input | 1 | Output enable |
| pwr_down | input | 1 | Power-down, active high |
| ser_out | output | 1 | Serial data |
| ser_valid | output | 1 | Serial output driven |
| frame_start | output | 1 | High during the start-bit cycle of each frame |

## Verification
The assertions watch every cycle for the following:
- the fixed start and stop bits of driven frames;
- a low line whenever the output is not driven;
- `ser_valid` changing only at a frame boundary;
- a sync frame following any request at a load edge, or any load edge inside an unfinished burst.

Only the bench scenarios can show the rest:
- the exact payload bit order;
- which of two successive words each capture phase takes;
- that a one-frame request yields exactly 1024 sync frames;
- that a long request extends the burst to its own length;
- that a word offered under a request never reaches the line.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
    localparam int DATA_W  = 10;
    localparam int FRAME_W = DATA_W + 2;
    localparam int PHASE_W = $clog2(FRAME_W);
    localparam int SYNC_HI = FRAME_W / 2;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic {MODE_DATA = 1'b0, MODE_SYNC = 1'b1} mode_e;

    typedef struct packed {
        logic   load;
        logic   first;
        logic   cap_pt_early;
        logic   cap_pt_mid;
        logic   last;
    } phase_evt_t;

    function automatic frame_t make_data_frame(input word_t w);
        frame_t f;
        f = '0;
        f[0] = 1'b1;
        for (int i = 0; i < DATA_W; i++) f[i+1] = w[i];
        f[FRAME_W-1] = 1'b0;
        return f;
    endfunction

    function automatic frame_t make_sync_frame();
        frame_t f;
        for (int i = 0; i < FRAME_W; i++) f[i] = (i < SYNC_HI);
        return f;
    endfunction
endpackage

// File: rtl/ecw_phase_gen.sv
module ecw_phase_gen
    import ecw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output phase_t     phase,
    output phase_evt_t evt
);
    localparam phase_t LAST = phase_t'(FRAME_W - 1);
    localparam phase_t MID  = phase_t'(SYNC_HI);

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    always_comb begin
        evt.last         = (phase == LAST);
        evt.load         = (phase == LAST);
        evt.first        = (phase == '0);
        evt.cap_pt_early = (phase == '0);
        evt.cap_pt_mid   = (phase == MID);
    end

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));
    a_r1_count: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/ecw_sync_ctrl.sv
module ecw_sync_ctrl
    import ecw_pkg::*;
#(
    parameter int MIN_SYNC = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  req,
    output logic  pick_sync,
    output mode_e mode
);
    localparam int CW = $clog2(MIN_SYNC + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_SYNC);

    logic          in_burst;
    logic [CW-1:0] sent;

    always_comb pick_sync = req || (in_burst && (sent < MIN_C));

    always_ff @(posedge clk) begin
        if (rst) begin
            in_burst <= 1'b0;
            sent     <= '0;
            mode     <= MODE_DATA;
        end else if (load) begin
            if (pick_sync) begin
                mode <= MODE_SYNC;
                if (!in_burst) begin
                    in_burst <= 1'b1;
                    sent     <= CW'(1);
                end else if (sent < MIN_C) begin
                    sent <= sent + 1'b1;
                end
            end else begin
                mode     <= MODE_DATA;
                in_burst <= 1'b0;
                sent     <= '0;
            end
        end
    end

    // R4: a request at a load edge yields a sync frame
    a_r4_req_sync: assert property (@(posedge clk) disable iff (rst)
        (load && req) |=> (mode == MODE_SYNC));
    // R5: an unfinished burst keeps sending sync frames
    a_r5_min_burst: assert property (@(posedge clk) disable iff (rst)
        (load && in_burst && (sent < MIN_C)) |=> (mode == MODE_SYNC));
    a_r6_end_data: assert property (@(posedge clk) disable iff (rst)
        (load && !req && in_burst && (sent >= MIN_C)) |=> (mode == MODE_DATA));
endmodule

// File: rtl/ecw_frame_shift.sv
module ecw_frame_shift
    import ecw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_evt_t evt,
    input  logic       cap_early,
    input  logic       req,
    input  logic       pick_sync,
    input  logic       drive_ok,
    input  word_t      din,
    output logic       ser_out,
    output logic       ser_valid
);
    localparam frame_t SYNC_FRAME = make_sync_frame();

    word_t  hold;
    frame_t shreg;
    logic   cap_now;

    always_comb cap_now = (cap_early ? evt.cap_pt_early : evt.cap_pt_mid) && !req;

    always_ff @(posedge clk) begin
        if (rst)          hold <= '0;
        else if (cap_now) hold <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            ser_valid <= 1'b0;
        end else if (evt.load) begin
            shreg     <= pick_sync ? SYNC_FRAME : make_data_frame(hold);
            ser_valid <= drive_ok;
        end else begin
            shreg     <= {1'b0, shreg[FRAME_W-1:1]};
        end
    end

    assign ser_out = ser_valid & shreg[0];

    // R7: the held word does not move while a request is active
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (rst)
        req |=> $stable(hold));
endmodule

// File: rtl/ecw_serializer.sv
module ecw_serializer
    import ecw_pkg::*;
#(
    parameter int MIN_SYNC = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              cap_early,
    input  logic              sync_a,
    input  logic              sync_b,
    input  logic              en,
    input  logic              pwr_down,
    output logic              ser_out,
    output logic              ser_valid,
    output logic              frame_start
);
    phase_t     phase;
    phase_evt_t evt;
    logic       req;
    logic       pick_sync;
    mode_e      mode;

    assign req         = sync_a | sync_b;
    assign frame_start = evt.first;

    ecw_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .evt   (evt)
    );

    ecw_sync_ctrl #(.MIN_SYNC(MIN_SYNC)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .load      (evt.load),
        .req       (req),
        .pick_sync (pick_sync),
        .mode      (mode)
    );

    ecw_frame_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cap_early (cap_early),
        .req       (req),
        .pick_sync (pick_sync),
        .drive_ok  (en & ~pwr_down),
        .din       (din),
        .ser_out   (ser_out),
        .ser_valid (ser_valid)
    );

    // R2: fixed start bit in driven data frames
    a_r2_start_bit: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && frame_start && mode == MODE_DATA) |-> ser_out);
    // R2: fixed stop bit
    a_r2_stop_bit: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && evt.last && mode == MODE_DATA) |-> !ser_out);
    // R4: sync frames begin high and end low
    a_r4_sync_shape: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && mode == MODE_SYNC) |-> (ser_out == (phase < phase_t'(SYNC_HI))));
    // R8: undriven line stays low
    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        !ser_valid |-> !ser_out);
    // R9: drive state only moves at a frame boundary
    a_r9_valid_boundary: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(ser_valid));
endmodule

// File: tb/test_ecw_serializer.sv
module test_ecw_serializer;
    import ecw_pkg::*;

    typedef struct {
        int          idx;
        logic [11:0] bits;
        logic        vld;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] din = '0;
    logic       cap_early = 1'b1;
    logic       sync_a = 1'b0;
    logic       sync_b = 1'b0;
    logic       en = 1'b1;
    logic       pwr_down = 1'b0;
    logic       ser_out, ser_valid, frame_start;

    int   checks = 0;
    int   failures = 0;
    int   mon_idx = 0;
    exp_t q[$];

    localparam logic [11:0] SYNC_EXP = 12'h03F;

    always #10 clk = ~clk;

    ecw_serializer i_ecw_serializer (
        .clk(clk), .rst(rst), .din(din), .cap_early(cap_early),
        .sync_a(sync_a), .sync_b(sync_b), .en(en), .pwr_down(pwr_down),
        .ser_out(ser_out), .ser_valid(ser_valid), .frame_start(frame_start)
    );

    function automatic logic [11:0] dframe(input logic [9:0] d);
        logic [11:0] f;
        f[0] = 1'b1;
        for (int i = 0; i < 10; i++) f[i+1] = d[i];
        f[11] = 1'b0;
        return f;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one word period: phase-0 values, then phase-3 values; expectation for next frame
    task automatic slot(input logic [9:0] d0, input logic [9:0] d1,
                        input logic [1:0] sy0, input logic [1:0] sy1,
                        input logic ce, input logic e, input logic pd,
                        input logic [11:0] exp_bits, input logic exp_vld, input string tag);
        exp_t x;
        @(negedge clk);
        while (!frame_start) @(negedge clk);
        #1;
        din = d0; {sync_b, sync_a} = sy0; cap_early = ce; en = e; pwr_down = pd;
        x.idx = mon_idx + 1; x.bits = exp_vld ? exp_bits : 12'h000; x.vld = exp_vld; x.tag = tag;
        q.push_back(x);
        repeat (3) @(negedge clk);
        #1;
        din = d1; {sync_b, sync_a} = sy1;
    endtask

    // monitor
    initial begin
        exp_t x;
        logic [11:0] got;
        logic        vok;
        forever begin
            @(negedge clk);
            if (!rst && frame_start) begin
                mon_idx++;
                if (q.size() > 0 && q[0].idx == mon_idx) begin
                    x = q.pop_front();
                    vok = 1'b1;
                    for (int k = 0; k < 12; k++) begin
                        if (k > 0) @(negedge clk);
                        got[k] = ser_out;
                        if (ser_valid !== x.vld) vok = 1'b0;
                    end
                    check(vok, {x.tag, " valid"}, {11'd0, ser_valid}, {11'd0, x.vld});
                    check(got === x.bits, {x.tag, " bits"}, got, x.bits);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t x0;
        logic ok;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        // R9: first partial frame undriven
        ok = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (ser_valid !== 1'b0 || ser_out !== 1'b0) ok = 1'b0;
        end
        check(ok, "R9 reset idle", {10'd0, ser_valid, ser_out}, 12'h000);
        x0.idx = 1; x0.bits = dframe(10'h000); x0.vld = 1'b1; x0.tag = "R9 first frame";
        q.push_back(x0);

        slot(10'h2A5, 10'h2A5, 2'b00, 2'b00, 1, 1, 0, dframe(10'h2A5), 1, "R1 lsb first");
        slot(10'h3FF, 10'h3FF, 2'b00, 2'b00, 1, 1, 0, dframe(10'h3FF), 1, "R2 all ones");
        slot(10'h000, 10'h000, 2'b00, 2'b00, 1, 1, 0, dframe(10'h000), 1, "R2 all zeros");
        slot(10'h0F0, 10'h30F, 2'b00, 2'b00, 1, 1, 0, dframe(10'h0F0), 1, "R3 early capture");
        slot(10'h155, 10'h3C3, 2'b00, 2'b00, 0, 1, 0, dframe(10'h3C3), 1, "R3 mid capture");
        slot(10'h111, 10'h111, 2'b00, 2'b00, 1, 0, 0, 12'h000, 0, "R8 enable low");
        slot(10'h099, 10'h099, 2'b00, 2'b00, 1, 1, 1, 12'h000, 0, "R8 power down");
        slot(10'h222, 10'h222, 2'b00, 2'b00, 1, 1, 0, dframe(10'h222), 1, "R8 driven again");

        // R4/R5: one-slot request on sync_a gives exactly 1024 sync frames
        slot(10'h333, 10'h333, 2'b01, 2'b01, 1, 1, 0, SYNC_EXP, 1, "R4 sync_a pattern");
        for (int i = 1; i < 1024; i++)
            slot(10'h044, 10'h044, 2'b00, 2'b00, 1, 1, 0, SYNC_EXP, 1, "R5 min burst");
        slot(10'h0A0, 10'h0A0, 2'b00, 2'b00, 1, 1, 0, dframe(10'h0A0), 1, "R5 burst end");

        // R6/R7: long request on sync_b, offered words ignored
        slot(10'h1FE, 10'h1FE, 2'b10, 2'b10, 1, 1, 0, SYNC_EXP, 1, "R4 sync_b pattern");
        for (int i = 1; i < 1100; i++)
            slot(10'(i), 10'(i), 2'b10, 2'b10, 1, 1, 0, SYNC_EXP, 1, "R6 extended burst");
        slot(10'h3AB, 10'h3AB, 2'b10, 2'b00, 1, 1, 0, dframe(10'h0A0), 1, "R7 word ignored");
        slot(10'h1C7, 10'h1C7, 2'b00, 2'b00, 1, 1, 0, dframe(10'h1C7), 1, "R6 data resumes");

        while (q.size() > 0) @(negedge clk);
        repeat (14) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule